// File: doc/BRIEF.md
# GPIO Port Register Block

This block is the register file and pad-control logic for a single sixteen-pin general-purpose I/O port. Software reaches it through a plain 32-bit register bus with a write strobe, a byte address, write data and combinational read data. Each pin has four configuration fields:

- a 2-bit direction/ownership mode;
- a 1-bit output driver type;
- a 2-bit pull selection;
- a 2-bit speed selection.

The pull and speed fields are only stored and presented to the pad ring.

Pin levels are seen by software through an input register. That register is fed by a two-stage synchronizer. The output level is held in an output register. Software can write that register as a whole word. It can also change it bit by bit through a write-only set/clear word, so that no read-modify-write is needed.

From the mode, the driver type and the output bit, the block derives three things for each pin: the pad output value, the pad output enable and an open-drain qualifier. It also flags the pins that are handed to a peripheral.

Register word offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | mode |
| 0x04 | driver type |
| 0x08 | pull |
| 0x0C | speed |
| 0x10 | input |
| 0x14 | output |
| 0x18 | set/clear |

Any other offset reads as zero.

Top module: `gpio_port_regs`

## Requirements
- R1: After synchronous reset:
  - every mode, driver type, pull and speed field is zero;
  - the output register is zero;
  - pad_oe is all zero.
- R2: The mode register at offset 0x00 holds a 2-bit field for pin n at bits [2n+1:2n]. Value 00 means input, value 01 means general output, and 10 or 11 means peripheral-owned. It reads back exactly as written.
- R3: The driver-type register at offset 0x04 holds one bit per pin, where 1 means open-drain and 0 means push-pull. It reads back as written. A pin in mode 01 with driver type 0 has pad_oe=1 and pad_od=0.
- R4: A pin in mode 01 with driver type 1 has pad_od=1, and pad_oe equal to the inverse of its output bit.
- R5: A pin in mode 00, 10 or 11 has pad_oe=0 whatever its output bit. pad_periph is 1 exactly for pins in mode 10 or 11.
- R6: The pull register at offset 0x08 and the speed register at offset 0x0C hold 2-bit fields at bits [2n+1:2n]. They read back as written and appear unchanged on pad_pull and pad_speed.
- R7: Writing the output register at offset 0x14 loads bits [15:0] and ignores bits [31:16]. The register reads back the stored value, and pad_out equals it from the cycle after the write.
- R8: Writing the set/clear word at offset 0x18 sets output bit n when write bit n (0..15) is 1, and clears it when write bit n+16 is 1. Bits written as zero leave the output unchanged.
- R9: If one set/clear write has both bit n and bit n+16 at 1, output bit n ends at 1.
- R10: Reading offset 0x18 returns zero.
- R11: The input register at offset 0x10 returns pad_in through two clocked stages. A change is not visible after one clock edge and is visible after the second.
- R12: Writes to the input register have no effect. Reads of an unmapped offset (0x1C) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 16 | Raw pin levels from the pads |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Pad driver enable per pin |
| pad_od | output | 16 | Open-drain qualifier per pin |
| pad_periph | output | 16 | Pin owned by a peripheral |
| pad_pull | output | 32 | Pull selection, 2 bits per pin |
| pad_speed | output | 32 | Speed selection, 2 bits per pin |

## Verification
A corrupted output register shows on pad_out and on the output register read in the cycle after the faulty write. That is why every set/clear case is checked right after its write, with the prior value chosen so that set, clear, untouched and contended bits each differ.

A mis-decoded mode or driver-type bit shows at once on pad_oe, pad_od or pad_periph. The bench therefore combines pins in all four modes with both output levels.

A missing or extra synchronizer stage is visible only in timing. So the input register is read both one and two edges after a pin change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_PINS  = 16;
    localparam int GPIO_BUS_W = 32;
    localparam int GPIO_ADR_W = 5;

    typedef enum logic [1:0] {
        PMODE_INPUT  = 2'b00,
        PMODE_OUTPUT = 2'b01,
        PMODE_PERA   = 2'b10,
        PMODE_PERB   = 2'b11
    } pin_mode_e;

    typedef enum logic [2:0] {
        RSEL_MODE   = 3'd0,
        RSEL_DRV    = 3'd1,
        RSEL_PULL   = 3'd2,
        RSEL_SPEED  = 3'd3,
        RSEL_IN     = 3'd4,
        RSEL_OUT    = 3'd5,
        RSEL_SETCLR = 3'd6,
        RSEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } bus_dec_t;

    function automatic reg_sel_e word_to_sel(input logic [2:0] word_idx);
        reg_sel_e s;
        case (word_idx)
            3'd0:    s = RSEL_MODE;
            3'd1:    s = RSEL_DRV;
            3'd2:    s = RSEL_PULL;
            3'd3:    s = RSEL_SPEED;
            3'd4:    s = RSEL_IN;
            3'd5:    s = RSEL_OUT;
            3'd6:    s = RSEL_SETCLR;
            default: s = RSEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic drive_enable(input pin_mode_e m, input logic od, input logic val);
        logic en;
        if (m != PMODE_OUTPUT) en = 1'b0;
        else if (od)           en = ~val;
        else                   en = 1'b1;
        return en;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS,
    parameter int DATA_W   = GPIO_BUS_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_dec_t              dec,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0]   drv_q,
    output logic [2*NUM_PINS-1:0] pull_q,
    output logic [2*NUM_PINS-1:0] speed_q
);
    localparam int FW = 2 * NUM_PINS;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            drv_q   <= '0;
            pull_q  <= '0;
            speed_q <= '0;
        end else if (dec.wr) begin
            case (dec.sel)
                RSEL_MODE:  mode_q  <= wdata[FW-1:0];
                RSEL_DRV:   drv_q   <= wdata[NUM_PINS-1:0];
                RSEL_PULL:  pull_q  <= wdata[FW-1:0];
                RSEL_SPEED: speed_q <= wdata[FW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS,
    parameter int DATA_W   = GPIO_BUS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_dec_t            dec,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] out_q
);
    logic [NUM_PINS-1:0] set_bits;
    logic [NUM_PINS-1:0] clr_bits;
    logic [NUM_PINS-1:0] out_d;

    assign set_bits = wdata[NUM_PINS-1:0];
    assign clr_bits = wdata[2*NUM_PINS-1:NUM_PINS];

    always_comb begin
        out_d = out_q;
        if (dec.wr && dec.sel == RSEL_OUT)
            out_d = wdata[NUM_PINS-1:0];
        else if (dec.wr && dec.sel == RSEL_SETCLR)
            out_d = (out_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = GPIO_PINS
) (
    input  logic [2*NUM_PINS-1:0] mode_q,
    input  logic [NUM_PINS-1:0]   drv_q,
    input  logic [NUM_PINS-1:0]   out_q,
    output logic [NUM_PINS-1:0]   oe,
    output logic [NUM_PINS-1:0]   od,
    output logic [NUM_PINS-1:0]   periph
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        pin_mode_e m;
        assign m         = pin_mode_e'(mode_q[2*n +: 2]);
        assign oe[n]     = drive_enable(m, drv_q[n], out_q[n]);
        assign od[n]     = (m == PMODE_OUTPUT) && drv_q[n];
        assign periph[n] = (m == PMODE_PERA) || (m == PMODE_PERB);
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int NUM_PINS    = GPIO_PINS,
    parameter int DATA_W      = GPIO_BUS_W,
    parameter int ADDR_W      = GPIO_ADR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_od,
    output logic [NUM_PINS-1:0]   pad_periph,
    output logic [2*NUM_PINS-1:0] pad_pull,
    output logic [2*NUM_PINS-1:0] pad_speed
);
    localparam int FW = 2 * NUM_PINS;

    bus_dec_t            dec;
    logic [FW-1:0]       mode_q;
    logic [NUM_PINS-1:0] drv_q;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] in_q;

    assign dec.wr  = bus_we;
    assign dec.sel = word_to_sel(bus_addr[ADDR_W-1:2]);

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst), .dec(dec), .wdata(bus_wdata),
        .mode_q(mode_q), .drv_q(drv_q), .pull_q(pad_pull), .speed_q(pad_speed)
    );

    gpio_out_reg #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .dec(dec), .wdata(bus_wdata), .out_q(out_q)
    );

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(pad_in), .synced(in_q)
    );

    gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) u_pad (
        .mode_q(mode_q), .drv_q(drv_q), .out_q(out_q),
        .oe(pad_oe), .od(pad_od), .periph(pad_periph)
    );

    assign pad_out = out_q;

    always_comb begin
        bus_rdata = '0;
        case (dec.sel)
            RSEL_MODE:  bus_rdata[FW-1:0]       = mode_q;
            RSEL_DRV:   bus_rdata[NUM_PINS-1:0] = drv_q;
            RSEL_PULL:  bus_rdata[FW-1:0]       = pad_pull;
            RSEL_SPEED: bus_rdata[FW-1:0]       = pad_speed;
            RSEL_IN:    bus_rdata[NUM_PINS-1:0] = in_q;
            RSEL_OUT:   bus_rdata[NUM_PINS-1:0] = out_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_PINS-1:0]   pad_in,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_od,
    input logic [NUM_PINS-1:0]   pad_periph
);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(5'h10);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(5'h14);
    localparam logic [ADDR_W-1:0] A_SC  = ADDR_W'(5'h18);

    logic [1:0] live_cyc;
    always_ff @(posedge clk) begin
        if (rst)               live_cyc <= '0;
        else if (live_cyc < 2) live_cyc <= live_cyc + 2'd1;
    end

    AST_SETCLR_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SC) |=>
        pad_out == (($past(pad_out) & ~$past(bus_wdata[2*NUM_PINS-1:NUM_PINS]))
                    | $past(bus_wdata[NUM_PINS-1:0])));  // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_we || (bus_addr != A_OUT && bus_addr != A_SC)) |=> $stable(pad_out));  // R7

    AST_OD_NO_DRIVE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_od & pad_out) == '0);  // R4

    AST_PERIPH_NO_OE: assert property (@(posedge clk) disable iff (rst)
        (pad_periph & pad_oe) == '0);  // R5

    AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SC) |-> bus_rdata == '0);  // R10

    AST_IN_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (live_cyc == 2'd2 && bus_addr == A_IN) |->
        bus_rdata[NUM_PINS-1:0] == $past(pad_in, 2));  // R11
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_periph(pad_periph)
);

// File: tb/tb_gpio_port_regs.sv
`timescale 1ns/1ps
module tb_gpio_port_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_periph;
    logic [31:0] pad_pull, pad_speed;

    always #4 clk = ~clk;

    gpio_port_regs dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
        .pad_periph(pad_periph), .pad_pull(pad_pull), .pad_speed(pad_speed)
    );

    localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_OD = 3, K_PER = 4, K_PULL = 5, K_SPD = 6;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // monitor: compares expected items against the ports at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_OUT:   act = {16'h0, pad_out};
                K_OE:    act = {16'h0, pad_oe};
                K_OD:    act = {16'h0, pad_od};
                K_PER:   act = {16'h0, pad_periph};
                K_PULL:  act = pad_pull;
                default: act = pad_speed;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk(input int kind, input logic [4:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(posedge clk); #1;
        pad_in = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(K_RD,  5'h00, 32'h0, "R1 mode after reset");
        chk(K_RD,  5'h14, 32'h0, "R1 output after reset");
        chk(K_OE,  5'h00, 32'h0, "R1 oe after reset");
        chk(K_PULL,5'h00, 32'h0, "R1 pull after reset");

        // R2 mode: pin0=01, pin1=01, pin2=10, pin15=11
        wr(5'h00, 32'hC000_0025);
        chk(K_RD, 5'h00, 32'hC000_0025, "R2 mode readback");
        // R3 driver type: pin1 open-drain
        wr(5'h04, 32'h0000_0002);
        chk(K_RD, 5'h04, 32'h0000_0002, "R3 driver readback");

        // R7 direct output write
        wr(5'h14, 32'h0000_0003);
        chk(K_OUT, 5'h00, 32'h0000_0003, "R7 pad_out after write");
        chk(K_OE,  5'h00, 32'h0000_0001, "R3 push-pull oe / R4 od high released");
        chk(K_OD,  5'h00, 32'h0000_0002, "R4 od qualifier");
        chk(K_PER, 5'h00, 32'h0000_8004, "R5 periph flags");

        // R4 clear pin1 -> open-drain drives low
        wr(5'h18, 32'h0002_0000);
        chk(K_OUT, 5'h00, 32'h0000_0001, "R8 clear bit");
        chk(K_OE,  5'h00, 32'h0000_0003, "R4 od drives on low");

        // R8 set and clear different bits
        wr(5'h18, 32'h0001_00F0);
        chk(K_RD, 5'h14, 32'h0000_00F0, "R8 set/clear mix");
        // R9 contended bit 8
        wr(5'h18, 32'h0100_0100);
        chk(K_OUT, 5'h00, 32'h0000_01F0, "R9 set wins");
        // R8 zero word no change
        wr(5'h18, 32'h0000_0000);
        chk(K_OUT, 5'h00, 32'h0000_01F0, "R8 zero word");
        // R10
        chk(K_RD, 5'h18, 32'h0, "R10 setclr reads zero");

        // R7 upper half ignored
        wr(5'h14, 32'hFFFF_1234);
        chk(K_RD, 5'h14, 32'h0000_1234, "R7 upper bits ignored");
        // R5 input pin4 with out=1 and periph pin2 with out=1 stay off
        chk(K_OE, 5'h00, 32'h0000_0003, "R5 oe off for input/periph");

        // R6 pull and speed
        wr(5'h08, 32'h1234_5678);
        wr(5'h0C, 32'h8765_4321);
        chk(K_RD,   5'h08, 32'h1234_5678, "R6 pull readback");
        chk(K_PULL, 5'h00, 32'h1234_5678, "R6 pad_pull");
        chk(K_RD,   5'h0C, 32'h8765_4321, "R6 speed readback");
        chk(K_SPD,  5'h00, 32'h8765_4321, "R6 pad_speed");

        // R11 two-stage input
        set_pins(16'hA5C3);
        chk(K_RD, 5'h10, 32'h0000_0000, "R11 not after one edge");
        chk(K_RD, 5'h10, 32'h0000_A5C3, "R11 visible after two edges");

        // R12 write to input ignored, unmapped reads zero
        wr(5'h10, 32'h0000_FFFF);
        chk(K_RD, 5'h10, 32'h0000_A5C3, "R12 input write ignored");
        chk(K_RD, 5'h1C, 32'h0, "R12 unmapped reads zero");

        // R1 reset again after configuration
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        chk(K_RD, 5'h00, 32'h0, "R1 mode after second reset");
        chk(K_RD, 5'h14, 32'h0, "R1 output after second reset");
        chk(K_SPD,5'h00, 32'h0, "R1 speed after second reset");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule